// File: doc/BRIEF.md
# DDR Read Capture and Resync

This block brings double-edge read data from an external memory into the system clock domain. It uses a short chain of registers and no FIFO or memory array. The input stage is clocked by the returning source-synchronous strobe. It captures each data pin twice per strobe period, once on the rising edge and once on the falling edge, and then presents both bits together as one single-edge word.

That word is resampled by a resync clock. The resync clock comes from the same source as the system clock and runs at the same frequency, but at a different phase. The resampled word then passes one more full-rate register. A two-bit phase select, chosen from the measured phase difference between the resync clock and the system clock, controls how the word is handed to the system clock. The word can be passed straight through or held for one more system cycle. In either case its two halves can also be swapped.

A qualifier pin marks which strobe periods carry real read data. It travels through the same registers as the data, so the read-valid output always lines up with its word.

Top module: `ddr_rd_resync`

## Requirements
- R1: A word is built from the bits captured on one rising strobe edge, which go in the upper half (bits 2*DQ_W-1 down to DQ_W), and the bits captured on the falling edge that follows, which go in the lower half (bits DQ_W-1 down to 0). The word comes out in this order when phase select is 0 or 1.
- R2: The qualifier is sampled on the same rising strobe edge as the upper half of a word. `rd_vld_o` is high in exactly the output cycle that carries that word.
- R3: With phase select 0, a word whose rising half is captured on the first strobe rising edge after system edge m appears on the outputs after system edge m+3. This holds when the strobe rises just after a system edge and the resync clock rises 3 ns before the next one, which are the phases used by the bench.
- R4: With phase select 1, the same word appears one system cycle later than in R3, after edge m+4.
- R5: Phase select 2 gives the latency of R3 and phase select 3 gives the latency of R4. In both, the halves are exchanged: the falling-edge bits go in the upper half and the rising-edge bits go in the lower half. The valid timing is unchanged.
- R6: The phase select is sampled only on a system clock edge. The sample is taken only when neither the last resync register nor the extra system register holds a valid word. A change made during a burst therefore has no effect on the rest of that burst.
- R7: Reset is synchronous and active high. While it is held, `rd_vld_o` and `rd_data_o` are 0. After it is released, `rd_vld_o` stays low until a qualified word arrives.
- R8: Strobe periods with the qualifier low never raise `rd_vld_o`. A run of back-to-back qualified words comes out as the same number of consecutive valid cycles, in order, with no gap and no repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; output and phase-select domain |
| rst | input | 1 | Synchronous active-high reset, applied in every clock domain |
| rsy_clk | input | 1 | Resync clock, same source and frequency as sys_clk |
| strb | input | 1 | Source-synchronous read strobe, already centred on the data eye |
| dq_i | input | DQ_W | Double-edge read data pins |
| dq_vld_i | input | 1 | Read qualifier, sampled with the rising-edge half |
| phase_sel_i | input | 2 | 0 direct, 1 one extra stage, 2 direct with swap, 3 extra stage with swap |
| rd_data_o | output | 2*DQ_W | Aligned read word in the system domain |
| rd_vld_o | output | 1 | High when rd_data_o carries a qualified word |

## Verification
For each strobe period, the bench records the word it drives together with the index of the system cycle in which its rising half is captured. Three system cycles later that word must appear on the outputs when phase select is 0 or 2, and four cycles later when it is 1 or 3. The outputs are sampled halfway through each system cycle, and the recorded entry at the matching offset is compared there.

The bench changes phase select only after ten idle cycles. One directed exception changes it in the middle of a burst. The bench then keeps expecting the old latency until the pipeline drains, and checks the new one on the next burst.

// File: rtl/ddr_rsy_pkg.sv
`timescale 1ns/1ps
package ddr_rsy_pkg;

    // Bit 0 adds a system-clock stage, bit 1 exchanges the word halves.
    typedef enum logic [1:0] {
        PH_DIRECT     = 2'd0,
        PH_DELAY      = 2'd1,
        PH_SWAP       = 2'd2,
        PH_DELAY_SWAP = 2'd3
    } ph_sel_e;

    function automatic logic ph_delayed(input ph_sel_e p);
        return p[0];
    endfunction

    function automatic logic ph_swapped(input ph_sel_e p);
        return p[1];
    endfunction

endpackage

// File: rtl/ddr_cap_stage.sv
`timescale 1ns/1ps
module ddr_cap_stage #(
    parameter int unsigned DQ_W = 16
) (
    input  logic              strb,
    input  logic              rst,
    input  logic [DQ_W-1:0]   dq_i,
    input  logic              dq_vld_i,
    output logic [2*DQ_W-1:0] pair_o,
    output logic              pair_vld_o
);
    logic [DQ_W-1:0] rise_q;
    logic [DQ_W-1:0] fall_q;
    logic            rise_vld_q;

    // Rising-edge half and its qualifier; the completed pair is re-registered
    // on the next rising edge, so it stays stable for a full strobe period.
    always_ff @(posedge strb) begin
        if (rst) begin
            rise_q     <= '0;
            rise_vld_q <= 1'b0;
            pair_o     <= '0;
            pair_vld_o <= 1'b0;
        end else begin
            rise_q     <= dq_i;
            rise_vld_q <= dq_vld_i;
            pair_o     <= {rise_q, fall_q};
            pair_vld_o <= rise_vld_q;
        end
    end

    always_ff @(negedge strb) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q <= dq_i;
        end
    end

endmodule

// File: rtl/rsy_pipe.sv
`timescale 1ns/1ps
module rsy_pipe #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NSTG   = 2
) (
    input  logic              rsy_clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              vld_i,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o
);
    localparam int unsigned LAST = NSTG - 1;

    logic [NSTG-1:0][WORD_W-1:0] w_q;
    logic [NSTG-1:0]             v_q;

    // Stage 0 aligns the strobe-domain pair; later stages run at full rate.
    always_ff @(posedge rsy_clk) begin
        if (rst) begin
            w_q <= '0;
            v_q <= '0;
        end else begin
            w_q[0] <= word_i;
            v_q[0] <= vld_i;
            for (int i = 1; i < int'(NSTG); i++) begin
                w_q[i] <= w_q[i-1];
                v_q[i] <= v_q[i-1];
            end
        end
    end

    assign word_o = w_q[LAST];
    assign vld_o  = v_q[LAST];

endmodule

// File: rtl/rsy_phase_mux.sv
`timescale 1ns/1ps
module rsy_phase_mux
    import ddr_rsy_pkg::*;
#(
    parameter int unsigned HALF_W = 16
) (
    input  logic                sys_clk,
    input  logic                rst,
    input  logic [1:0]          phase_sel_i,
    input  logic [2*HALF_W-1:0] c_word_i,
    input  logic                c_vld_i,
    output logic [2*HALF_W-1:0] rd_data_o,
    output logic                rd_vld_o
);
    localparam int unsigned WORD_W = 2 * HALF_W;

    ph_sel_e             sel_q;
    logic [WORD_W-1:0]   d_word;
    logic                d_vld;
    logic [WORD_W-1:0]   src_word;
    logic                src_vld;
    logic [WORD_W-1:0]   out_word;
    logic                busy;

    assign busy = c_vld_i | d_vld;

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            sel_q <= PH_DIRECT;
        end else if (!busy) begin
            sel_q <= ph_sel_e'(phase_sel_i);
        end
    end

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            d_word <= '0;
            d_vld  <= 1'b0;
        end else begin
            d_word <= c_word_i;
            d_vld  <= c_vld_i;
        end
    end

    always_comb begin
        src_word = ph_delayed(sel_q) ? d_word : c_word_i;
        src_vld  = ph_delayed(sel_q) ? d_vld  : c_vld_i;
        if (ph_swapped(sel_q)) begin
            out_word = {src_word[HALF_W-1:0], src_word[WORD_W-1:HALF_W]};
        end else begin
            out_word = src_word;
        end
    end

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            rd_data_o <= '0;
            rd_vld_o  <= 1'b0;
        end else begin
            rd_data_o <= out_word;
            rd_vld_o  <= src_vld;
        end
    end

    // R6
    sel_hold_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (c_vld_i || d_vld) |=> (sel_q == $past(sel_q)));

    // R3
    direct_lat_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (sel_q == PH_DIRECT) |=>
            ((rd_vld_o == $past(c_vld_i)) && (rd_data_o == $past(c_word_i))));

    // R4
    delay_lat_chk: assert property (@(posedge sys_clk) disable iff (rst)
        ((sel_q == PH_DELAY) && ($past(sel_q) == PH_DELAY)) |=>
            (rd_vld_o == $past(c_vld_i, 2)));

    // R5
    swap_half_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (sel_q == PH_SWAP) |=>
            (rd_data_o == {$past(c_word_i[HALF_W-1:0]), $past(c_word_i[WORD_W-1:HALF_W])}));

    // R7
    rst_clear_chk: assert property (@(posedge sys_clk)
        rst |=> (!rd_vld_o && (rd_data_o == '0)));

endmodule

// File: rtl/ddr_rd_resync.sv
`timescale 1ns/1ps
module ddr_rd_resync #(
    parameter int unsigned DQ_W    = 16,
    parameter int unsigned RSY_STG = 2
) (
    input  logic              sys_clk,
    input  logic              rst,
    input  logic              rsy_clk,
    input  logic              strb,
    input  logic [DQ_W-1:0]   dq_i,
    input  logic              dq_vld_i,
    input  logic [1:0]        phase_sel_i,
    output logic [2*DQ_W-1:0] rd_data_o,
    output logic              rd_vld_o
);
    localparam int unsigned WORD_W = 2 * DQ_W;

    logic [WORD_W-1:0] pair_word;
    logic              pair_vld;
    logic [WORD_W-1:0] c_word;
    logic              c_vld;

    ddr_cap_stage #(.DQ_W(DQ_W)) cap_i (
        .strb       (strb),
        .rst        (rst),
        .dq_i       (dq_i),
        .dq_vld_i   (dq_vld_i),
        .pair_o     (pair_word),
        .pair_vld_o (pair_vld)
    );

    rsy_pipe #(.WORD_W(WORD_W), .NSTG(RSY_STG)) rsy_i (
        .rsy_clk (rsy_clk),
        .rst     (rst),
        .word_i  (pair_word),
        .vld_i   (pair_vld),
        .word_o  (c_word),
        .vld_o   (c_vld)
    );

    rsy_phase_mux #(.HALF_W(DQ_W)) mux_i (
        .sys_clk     (sys_clk),
        .rst         (rst),
        .phase_sel_i (phase_sel_i),
        .c_word_i    (c_word),
        .c_vld_i     (c_vld),
        .rd_data_o   (rd_data_o),
        .rd_vld_o    (rd_vld_o)
    );

endmodule

// File: tb/ddr_rd_resync_tb.sv
`timescale 1ns/1ps
module ddr_rd_resync_tb_top;
    localparam int DW = 16;
    localparam int WW = 2 * DW;

    logic          sys_clk = 1'b0;
    logic          rsy_clk = 1'b0;
    logic          strb    = 1'b0;
    logic          rst     = 1'b1;
    logic [DW-1:0] dq      = '0;
    logic          dq_vld  = 1'b0;
    logic [1:0]    phase_sel = 2'd0;
    logic [WW-1:0] rd_data;
    logic          rd_vld;

    ddr_rd_resync #(.DQ_W(DW), .RSY_STG(2)) dut_i (
        .sys_clk     (sys_clk),
        .rst         (rst),
        .rsy_clk     (rsy_clk),
        .strb        (strb),
        .dq_i        (dq),
        .dq_vld_i    (dq_vld),
        .phase_sel_i (phase_sel),
        .rd_data_o   (rd_data),
        .rd_vld_o    (rd_vld)
    );

    // 100 MHz system clock rising at 5; resync rises 3 ns before it; strobe 1 ns after.
    initial begin #5; forever begin sys_clk = 1'b1; #5; sys_clk = 1'b0; #5; end end
    initial begin #2; forever begin rsy_clk = 1'b1; #5; rsy_clk = 1'b0; #5; end end
    initial begin #6; forever begin strb    = 1'b1; #5; strb    = 1'b0; #5; end end

    int            cyc = 0;
    logic [WW-1:0] exp_w [0:255];
    logic          exp_v [0:255];
    int            m_mode = 0;
    string         tag = "R3";
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            exp_w[i] = '0;
            exp_v[i] = 1'b0;
        end
    end

    function automatic logic [WW-1:0] model_word(input logic [WW-1:0] w, input int mode);
        if (mode >= 2) return {w[DW-1:0], w[WW-1:DW]};
        return w;
    endfunction

    function automatic int model_lat(input int mode);
        return (mode % 2 == 1) ? 4 : 3;
    endfunction

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, expv);
        end
    endtask

    // Drives one strobe period: rising half before the rising edge, falling half after it.
    task automatic drive_word(input logic [DW-1:0] r, input logic [DW-1:0] f, input logic v);
        @(negedge strb);
        #3;
        dq     = r;
        dq_vld = v;
        @(posedge strb);
        exp_w[cyc % 256] = {r, f};
        exp_v[cyc % 256] = v;
        #3;
        dq = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_word(DW'($urandom()), DW'($urandom()), 1'b0);
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) drive_word(DW'($urandom()), DW'($urandom()), 1'b1);
    endtask

    task automatic new_mode(input int mode, input string t);
        idle(10);
        phase_sel = 2'(mode);
        m_mode    = mode;
        tag       = t;
        idle(3);
    endtask

    function automatic string mode_tag(input int mode);
        if (mode == 0) return "R3";
        if (mode == 1) return "R4";
        return "R5";
    endfunction

    // Output checker: samples mid-cycle, compares with the entry due 3 or 4 cycles back.
    initial begin
        forever begin
            @(posedge sys_clk);
            cyc = cyc + 1;
            #5;
            if (rst) begin
                if (cyc > 3) begin
                    chk("R7", WW'(rd_vld), '0);
                    chk("R7", rd_data, '0);
                end
            end else begin
                int idx;
                idx = (cyc - model_lat(m_mode)) % 256;
                chk(exp_v[idx] ? "R2" : "R8", WW'(rd_vld), WW'(exp_v[idx]));
                if (exp_v[idx]) begin
                    chk({"R1 ", tag}, rd_data, model_word(exp_w[idx], m_mode));
                end
            end
        end
    end

    initial begin
        void'($urandom(32'd4099));
        rst = 1'b1;
        idle(12);
        #1 rst = 1'b0;

        // Directed: single word, then a long back-to-back run (R8), in each mode.
        for (int m = 0; m < 4; m++) begin
            new_mode(m, mode_tag(m));
            burst(1);
            idle(4);
            drive_word(16'hA5C3, 16'h3C5A, 1'b1);
            drive_word(16'hFFFF, 16'h0000, 1'b1);
            idle(2);
            tag = "R8";
            burst(40);
            tag = mode_tag(m);
        end

        // R6: phase select moved in the middle of a burst keeps the old latency.
        new_mode(1, "R6");
        for (int i = 0; i < 10; i++) begin
            if (i == 5) phase_sel = 2'd0;
            drive_word(DW'($urandom()), DW'($urandom()), 1'b1);
        end
        idle(10);
        m_mode = 0;
        burst(6);

        // Random sessions.
        for (int s = 0; s < 12; s++) begin
            int m;
            m = int'($urandom() % 4);
            new_mode(m, mode_tag(m));
            for (int b = 0; b < 6; b++) begin
                burst(1 + int'($urandom() % 12));
                idle(int'($urandom() % 5));
            end
        end

        idle(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule